// File: doc/BRIEF.md
# Inverter Gate-Stage Fault Supervisor

This block sits between a PWM generator and the gate drivers of a three-phase inverter bridge. It receives one high-active switch command for each upper and each lower switch. It also receives digitized, clock-synchronous flags for four conditions: lower-side overcurrent, lower control-supply undervoltage, over-temperature, and one undervoltage flag per phase for the upper (bootstrap) supplies. Its outputs are a gated enable for each switch and an active-low fault line, which models an open-drain pin.

Each fault class has its own rule. An overcurrent produces a fault pulse of fixed width. Lower-supply undervoltage and over-temperature hold the fault line low for as long as the condition lasts, and never for less than the minimum width. An upper-supply undervoltage switches off only its own phase's upper switch, without any fault indication. After any shutdown, an enable returns only when its command produces a new low-to-high transition. A command that was held high throughout never re-enables its switch. The minimum fault width is a clock-cycle count set by a parameter, sized so that it covers 20 µs at the system clock.

Enables are combinational from the commands and flags, so a shutdown takes effect in the same cycle in which a flag is presented. Timing state is updated on the rising clock edge. Reset is synchronous and active high.

Top module: `invp_fault_seq`

## Requirements
- R1: While `oc_i` is 1, all of `drv_lo_o` are 0 in that same cycle, whatever the lower commands are.
- R2: A 0-to-1 transition of `oc_i` drives `fault_n_o` to 0 for exactly MIN_PULSE_CYC cycles, counted from the cycle in which the flag first reads 1. This holds however long the flag then stays high, as long as no other fault is pending.
- R3: While `uv_lo_i` or `ot_i` is 1, all of `drv_lo_o` are 0 and `fault_n_o` is 0.
- R4: A level fault (`uv_lo_i` or `ot_i`) that lasts d cycles keeps `fault_n_o` at 0 for max(d, MIN_PULSE_CYC) cycles from its onset.
- R5: When bit p of `uv_hi_i` is 1, bit p of `drv_hi_o` is 0. The other upper enables, all lower enables and `fault_n_o` are unaffected. Bit p is the same phase index in every per-phase vector.
- R6: After a lower shutdown (R1 or R3) ends, a lower enable stays 0 while its command stays 1. It returns only in a cycle in which the command reads 1 after reading 0 in the previous cycle, and that transition must occur after the shutdown has ended. Toggling the command during the shutdown does not re-enable the switch.
- R7: After `uv_hi_i[p]` returns to 0, `drv_hi_o[p]` follows the same fresh-rising-edge rule as in R6.
- R8: With no shutdown active and a channel already re-armed by a rising edge, each enable equals its command in the same cycle (1 = switch on).
- R9: When faults overlap, `fault_n_o` stays 0 until every running minimum-width window has expired and every level fault has cleared.
- R10: While `rst` is 1, `fault_n_o` is 1 and every enable is 0. After `rst` falls, every enable requires a fresh rising edge of its command, and no fault window started before reset is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_hi_i | input | PHASES | Upper switch commands, 1 = on |
| pwm_lo_i | input | PHASES | Lower switch commands, 1 = on |
| oc_i | input | 1 | Lower-side overcurrent flag |
| uv_lo_i | input | 1 | Lower control-supply undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| uv_hi_i | input | PHASES | Per-phase upper-supply undervoltage flags |
| drv_hi_o | output | PHASES | Gated upper switch enables |
| drv_lo_o | output | PHASES | Gated lower switch enables |
| fault_n_o | output | 1 | Fault indication, 0 = fault, 1 = idle |

## Verification
The assertions assume the following about the inputs:
- Every command and every flag is synchronous to `clk`.
- Each input holds one value for a whole cycle, so that a transition seen at one edge is a genuine change of level.
- `rst` is applied synchronously.

The stimulus meets these assumptions by changing inputs only one nanosecond after a rising edge and sampling outputs shortly after that. Every flag and command therefore has a single settled value at each edge.

The sweeps cover three fault kinds and fault durations both below and above the minimum width, on a reduced minimum width of eight cycles.

// File: rtl/invp_pkg.sv
package invp_pkg;
  localparam int unsigned INVP_PHASES_DEF = 3;
  // 20 us at a 200 MHz system clock
  localparam int unsigned INVP_MIN_DEF    = 4000;

  function automatic int unsigned invp_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/invp_edge_arm.sv
// One switch channel: the enable is granted only after a fresh rising edge of
// the command that occurs outside any block period.
module invp_edge_arm (
  input  logic clk,
  input  logic rst,
  input  logic cmd_i,
  input  logic block_i,
  output logic en_o
);
  logic prev_q;
  logic armed_q;
  logic rise;

  assign rise = cmd_i & ~prev_q;
  assign en_o = ~rst & cmd_i & ~block_i & (armed_q | rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;          // treat the command as already high
      armed_q <= 1'b0;
    end else begin
      prev_q <= cmd_i;
      if (block_i)   armed_q <= 1'b0;
      else if (rise) armed_q <= 1'b1;
    end
  end

  AST_FRESH_EDGE: assert property (@(posedge clk) disable iff (rst) $rose(en_o) |-> !$past(cmd_i)); // R6 R7
endmodule

// File: rtl/invp_guard_bank.sv
module invp_guard_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cmd_i,
  input  logic [N-1:0] block_i,
  output logic [N-1:0] en_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    invp_edge_arm u_arm (
      .clk     (clk),
      .rst     (rst),
      .cmd_i   (cmd_i[i]),
      .block_i (block_i[i]),
      .en_o    (en_o[i])
    );
  end
endmodule

// File: rtl/invp_min_pulse.sv
// Minimum-width window: busy from the trigger cycle for MIN cycles; a new
// trigger restarts the full window.
module invp_min_pulse #(
  parameter int unsigned MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned W = invp_pkg::invp_cnt_w(MIN);
  localparam logic [W-1:0] RELOAD = W'(MIN - 1);

  logic [W-1:0] cnt_q;

  assign busy_o = trig_i | (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (trig_i)       cnt_q <= RELOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= RELOAD); // R2
endmodule

// File: rtl/invp_fault_seq.sv
module invp_fault_seq #(
  parameter int unsigned PHASES        = invp_pkg::INVP_PHASES_DEF,
  parameter int unsigned MIN_PULSE_CYC = invp_pkg::INVP_MIN_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] pwm_hi_i,
  input  logic [PHASES-1:0] pwm_lo_i,
  input  logic              oc_i,
  input  logic              uv_lo_i,
  input  logic              ot_i,
  input  logic [PHASES-1:0] uv_hi_i,
  output logic [PHASES-1:0] drv_hi_o,
  output logic [PHASES-1:0] drv_lo_o,
  output logic              fault_n_o
);
  localparam int unsigned LW = $clog2(MIN_PULSE_CYC + 1);

  logic lvl;
  logic oc_prev_q, lvl_prev_q;
  logic trig_oc, trig_lvl;
  logic oc_busy, lvl_busy;
  logic blk_lo;

  assign lvl      = uv_lo_i | ot_i;
  assign blk_lo   = oc_i | lvl;
  assign trig_oc  = oc_i & ~oc_prev_q;
  assign trig_lvl = lvl & ~lvl_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_prev_q  <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      oc_prev_q  <= oc_i;
      lvl_prev_q <= lvl;
    end
  end

  invp_min_pulse #(.MIN(MIN_PULSE_CYC)) u_oc_win (
    .clk (clk), .rst (rst), .trig_i (trig_oc), .busy_o (oc_busy)
  );

  invp_min_pulse #(.MIN(MIN_PULSE_CYC)) u_lvl_win (
    .clk (clk), .rst (rst), .trig_i (trig_lvl), .busy_o (lvl_busy)
  );

  assign fault_n_o = rst | ~(oc_busy | lvl_busy | lvl);

  invp_guard_bank #(.N(PHASES)) u_hi_bank (
    .clk (clk), .rst (rst), .cmd_i (pwm_hi_i), .block_i (uv_hi_i), .en_o (drv_hi_o)
  );

  invp_guard_bank #(.N(PHASES)) u_lo_bank (
    .clk (clk), .rst (rst), .cmd_i (pwm_lo_i), .block_i ({PHASES{blk_lo}}), .en_o (drv_lo_o)
  );

  // checker state: length of the current fault-low run
  logic [LW-1:0] low_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)                                   low_cnt_q <= '0;
    else if (fault_n_o)                        low_cnt_q <= '0;
    else if (low_cnt_q != LW'(MIN_PULSE_CYC))  low_cnt_q <= low_cnt_q + 1'b1;
  end

  AST_LO_SHUTDOWN: assert property (@(posedge clk) disable iff (rst) (oc_i | uv_lo_i | ot_i) |-> (drv_lo_o == '0)); // R1
  AST_LEVEL_FAULT: assert property (@(posedge clk) disable iff (rst) (uv_lo_i | ot_i) |-> !fault_n_o); // R3
  AST_OC_FAULT: assert property (@(posedge clk) disable iff (rst) $rose(oc_i) |-> !fault_n_o); // R2
  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst) $rose(fault_n_o) |-> (low_cnt_q >= LW'(MIN_PULSE_CYC))); // R4
  AST_RESET_IDLE: assert property (@(posedge clk) rst |-> (fault_n_o && drv_hi_o == '0 && drv_lo_o == '0)); // R10
  for (genvar p = 0; p < PHASES; p++) begin : g_hi_chk
    AST_HI_UV_OFF: assert property (@(posedge clk) disable iff (rst) uv_hi_i[p] |-> !drv_hi_o[p]); // R5
  end
endmodule

// File: tb/invp_fault_seq_bench.sv
`timescale 1ns/1ps
module invp_fault_seq_bench;
  localparam int MINC = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] pwm_hi, pwm_lo, uv_hi;
  logic       oc, uv_lo, ot;
  logic [2:0] drv_hi, drv_lo;
  logic       fault_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  invp_fault_seq #(.PHASES(3), .MIN_PULSE_CYC(MINC)) u_invp_fault_seq (
    .clk (clk), .rst (rst), .pwm_hi_i (pwm_hi), .pwm_lo_i (pwm_lo),
    .oc_i (oc), .uv_lo_i (uv_lo), .ot_i (ot), .uv_hi_i (uv_hi),
    .drv_hi_o (drv_hi), .drv_lo_o (drv_lo), .fault_n_o (fault_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic rearm_lo();
    cyc(); pwm_lo = 3'b000;
    cyc(); pwm_lo = 3'b111; #1;
    chk("R6 rearm lo", {29'd0, drv_lo}, 32'd7);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; pwm_hi = 3'b111; pwm_lo = 3'b111; uv_hi = 0; oc = 0; uv_lo = 0; ot = 1;
    cyc(); cyc(); #1;
    // R10: held in reset with a level fault present
    chk("R10 fault_n in reset", {31'd0, fault_n}, 32'd1);
    chk("R10 drv_hi in reset",  {29'd0, drv_hi}, 32'd0);
    chk("R10 drv_lo in reset",  {29'd0, drv_lo}, 32'd0);
    cyc(); rst = 0; ot = 0; #1;
    chk("R10 held-high no enable hi", {29'd0, drv_hi}, 32'd0);
    chk("R10 held-high no enable lo", {29'd0, drv_lo}, 32'd0);
    chk("R10 fault idle after reset", {31'd0, fault_n}, 32'd1);
    cyc(); pwm_hi = 0; pwm_lo = 0;
    cyc(); pwm_hi = 3'b111; pwm_lo = 3'b111; #1;
    chk("R10 fresh edge enables hi", {29'd0, drv_hi}, 32'd7);
    chk("R10 fresh edge enables lo", {29'd0, drv_lo}, 32'd7);

    // R8: all command patterns pass straight through once armed
    for (int pat = 0; pat < 64; pat++) begin
      cyc(); pwm_hi = pat[2:0]; pwm_lo = pat[5:3]; #1;
      chk("R8 hi follow", {29'd0, drv_hi}, {29'd0, pat[2:0]});
      chk("R8 lo follow", {29'd0, drv_lo}, {29'd0, pat[5:3]});
    end
    cyc(); pwm_hi = 3'b111; pwm_lo = 3'b111;

    // R1-R4, R6 sweep: fault kind x duration
    for (int kind = 0; kind < 3; kind++) begin
      for (int d = 1; d <= 12; d++) begin
        int span;
        span = (kind == 0) ? MINC : ((d > MINC) ? d : MINC);
        for (int t = 0; t <= d + MINC + 1; t++) begin
          cyc();
          oc    = (kind == 0) && (t < d);
          uv_lo = (kind == 1) && (t < d);
          ot    = (kind == 2) && (t < d);
          #1;
          if (kind == 0) chk("R2 oc pulse", {31'd0, fault_n}, (t < span) ? 32'd0 : 32'd1);
          else           chk("R4 level min width", {31'd0, fault_n}, (t < span) ? 32'd0 : 32'd1);
          if (t < d) chk((kind == 0) ? "R1 lo off" : "R3 lo off", {29'd0, drv_lo}, 32'd0);
          else       chk("R6 held high stays off", {29'd0, drv_lo}, 32'd0);
          chk("R5 hi unaffected by lo faults", {29'd0, drv_hi}, 32'd7);
        end
        rearm_lo();
      end
    end

    // R1/R6: toggling during an overcurrent does not re-enable
    for (int t = 0; t < 6; t++) begin
      cyc(); oc = 1;
      pwm_lo = (t == 2) ? 3'b000 : 3'b111; #1;
      chk("R1 toggle during oc", {29'd0, drv_lo}, 32'd0);
    end
    cyc(); oc = 0; #1;
    chk("R6 no enable after oc toggle", {29'd0, drv_lo}, 32'd0);
    for (int t = 0; t < MINC; t++) cyc();
    rearm_lo();

    // R5/R7: per-phase upper undervoltage
    for (int p = 0; p < 3; p++) begin
      for (int t = 0; t < 3; t++) begin
        cyc(); uv_hi = 3'(1 << p); #1;
        chk("R5 only phase off", {29'd0, drv_hi}, {29'd0, 3'(7 & ~(1 << p))});
        chk("R5 no fault", {31'd0, fault_n}, 32'd1);
        chk("R5 lo untouched", {29'd0, drv_lo}, 32'd7);
      end
      cyc(); uv_hi = 0; #1;
      chk("R7 held high stays off", {29'd0, drv_hi}, {29'd0, 3'(7 & ~(1 << p))});
      cyc(); pwm_hi = 3'(7 & ~(1 << p));
      cyc(); pwm_hi = 3'b111; #1;
      chk("R7 fresh edge restores", {29'd0, drv_hi}, 32'd7);
    end

    // R9: oc at t0 (1 cycle), ot at t3 (2 cycles) -> low until t < 3+MINC
    for (int t = 0; t < 15; t++) begin
      cyc(); oc = (t == 0); ot = (t == 3) || (t == 4); #1;
      chk("R9 overlap a", {31'd0, fault_n}, (t < 3 + MINC) ? 32'd0 : 32'd1);
    end
    rearm_lo();
    // R9: ot held 16 cycles, oc at t12 -> low until t < 12+MINC
    for (int t = 0; t < 24; t++) begin
      cyc(); ot = (t < 16); oc = (t == 12); #1;
      chk("R9 overlap b", {31'd0, fault_n}, (t < 12 + MINC) ? 32'd0 : 32'd1);
    end
    rearm_lo();

    // R10: reset in the middle of an overcurrent window
    cyc(); oc = 1;
    cyc(); oc = 0;
    cyc(); rst = 1; #1;
    chk("R10 reset ends pulse", {31'd0, fault_n}, 32'd1);
    chk("R10 reset drops enables", {29'd0, drv_lo}, 32'd0);
    cyc(); rst = 0;
    for (int t = 0; t < 3; t++) begin
      cyc(); #1;
      chk("R10 no leftover window", {31'd0, fault_n}, 32'd1);
      chk("R10 needs fresh edge", {29'd0, drv_lo | drv_hi}, 32'd0);
    end
    rearm_lo();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule